// File: doc/BRIEF.md
# MMU Control and Fault Register File

This block is the software-visible register file of a memory management unit. A CPU reaches it through a simple register bus with separate read and write strobes and a byte offset. It holds seven registers: the control word, the context table base, the current context number, a synchronous fault status word and its fault address, and an asynchronous fault status word and its address. The translation logic reports faults through two capture ports, one for synchronous faults and one for asynchronous faults. The block turns each synchronous fault into a one-cycle trap request unless software has selected the suppress-trap mode.

From the control word the block drives the translation enable and the store-ordering mode to the rest of the core. When translation is disabled, the translation datapath passes addresses to the bus as physical addresses. Trap delivery inside the CPU and the translation datapath are outside this block.

The synchronous status word tracks whether its contents were overwritten. If hardware records a second fault before software has read the status, the overwrite flag tells software that the first fault's details are lost.

Top module: `mmu_csr`

## Requirements
- R1: While `rst` is high on a rising edge, and after it, translation enable, suppress-trap and store-ordering select are 0, no fault is pending and `trap_req` is 0. The control word then reads `{IMPL, VERS, 24'h0}`.
- R2: The control word at offset 0x000 holds the implementation field in [31:28] and the version field in [27:24]. Both come from parameters and are read-only. Bits [23:8] are free storage. Bit [7] is the store-ordering select (1 = partial, 0 = total) and drives `pso_mode`. Bits [6:2] read 0. Bit [1] is suppress-trap. Bit [0] is translation enable and drives `xlat_en`.
- R3: The context table base at 0x100 stores bits [31:2] and reads 0 in [1:0]; it is presented on `ctx_tbl_ptr`. The context register at 0x200 keeps the low CTX_W bits, reads 0 above them, and is presented on `ctx_id`.
- R4: `reg_rdata` holds the addressed register one cycle after a read strobe. An offset that is not one of 0x000, 0x100, ..., 0x600 reads 0, and a write to it changes nothing. Writes to the four fault registers at 0x300 to 0x600 are ignored.
- R5: A synchronous capture fills the status word at 0x300 as follows: [17:10] bus error bits, [9:8] table level, [7:5] access type (0 user load, 1 supervisor load, 2 user fetch, 3 supervisor fetch, 4 user data store, 5 supervisor data store, 6 user instruction-space store, 7 supervisor instruction-space store), [4:2] fault type, [1] address valid, [0] overwrite. Bits [31:18] read 0.
- R6: With suppress-trap at 0, a capture in cycle t makes `trap_req` high in cycle t+1 only.
- R7: With suppress-trap at 1, a capture is still recorded but raises no trap. The exception is a capture whose address space is 9, which still traps.
- R8: A capture while an earlier fault is pending and unread sets the overwrite bit. A read of 0x300 returns the value held before the read and clears the overwrite bit and the pending flag. A capture in the same cycle as that read records the new fault with overwrite 0.
- R9: The fault address at 0x400 loads the captured address only when the capture flags its address as valid. Otherwise the register keeps its old value.
- R10: An asynchronous capture sets status 0x500 as follows: [12] uncorrectable, [11] bus timeout, [10] bus error, [7:4] high nibble of the physical address, [0] occurred = 1, all other bits 0. It also loads 0x600 with the address. A read of 0x500 clears only bit [0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| flt_valid | input | 1 | Synchronous fault capture strobe |
| flt_ebe | input | 8 | Bus error bits of the fault |
| flt_level | input | 2 | Table level of the fault |
| flt_acc | input | 3 | Access type code |
| flt_type | input | 3 | Fault type code |
| flt_addr_ok | input | 1 | Fault address is meaningful |
| flt_space | input | 8 | Address space identifier of the access |
| flt_vaddr | input | 32 | Faulting virtual address |
| afl_valid | input | 1 | Asynchronous fault capture strobe |
| afl_uce | input | 1 | Uncorrectable error |
| afl_bto | input | 1 | Bus timeout |
| afl_berr | input | 1 | Generic bus error |
| afl_hi | input | 4 | High nibble of the faulting physical address |
| afl_addr | input | 32 | Faulting physical address, low word |
| trap_req | output | 1 | One-cycle trap request to the CPU |
| xlat_en | output | 1 | Translation enable |
| pso_mode | output | 1 | Partial store ordering selected |
| ctx_tbl_ptr | output | 32 | Context table base register |
| ctx_id | output | CTX_W | Current context number |

## Verification
The hardest case to reach is a fault capture in the same cycle as a status read. The read must still return the old record, and the new record must appear with its overwrite bit clear. The bench raises the capture strobe and the read strobe in the same cycle. It then reads the status twice: the first read shows the earlier fault, the second shows the new fault with no overwrite. The suppress-trap exception for address space 9 and the back-to-back captures that set the overwrite bit are reached the same way. The bench writes the control word and then issues captures without any read in between.

// File: rtl/mmu_csr_pkg.sv
package mmu_csr_pkg;

  localparam int DATA_W  = 32;
  localparam int IDX_LSB = 8;
  localparam int IDX_W   = 3;

  typedef enum logic [IDX_W-1:0] {
    SEL_CTRL = 3'd0,
    SEL_CTP  = 3'd1,
    SEL_CTX  = 3'd2,
    SEL_FSR  = 3'd3,
    SEL_FAR  = 3'd4,
    SEL_AFSR = 3'd5,
    SEL_AFAR = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [7:0] ebe;
    logic [1:0] level;
    logic [2:0] acc;
    logic [2:0] ftype;
    logic       addr_ok;
  } fault_rec_t;

  localparam logic [7:0] TRAP_ALWAYS_SPACE = 8'd9;

endpackage

// File: rtl/mmu_csr_ctrl.sv
module mmu_csr_ctrl
  import mmu_csr_pkg::*;
#(
  parameter logic [3:0] IMPL  = 4'hA,
  parameter logic [3:0] VERS  = 4'h3,
  parameter int         CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_ctp,
  input  logic              wr_ctx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] ctp_word,
  output logic [DATA_W-1:0] ctx_word,
  output logic [CTX_W-1:0]  ctx_q,
  output logic              en_q,
  output logic              pso_q,
  output logic              nofault_q
);

  localparam int CTX_PAD = DATA_W - CTX_W;

  logic [15:0] sysctl_q;
  logic [29:0] ctp_q;

  // R1 R2 R3: writable fields, cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      sysctl_q  <= '0;
      pso_q     <= 1'b0;
      nofault_q <= 1'b0;
      en_q      <= 1'b0;
      ctp_q     <= '0;
      ctx_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        sysctl_q  <= wdata[23:8];
        pso_q     <= wdata[7];
        nofault_q <= wdata[1];
        en_q      <= wdata[0];
      end
      if (wr_ctp) ctp_q <= wdata[31:2];
      if (wr_ctx) ctx_q <= wdata[CTX_W-1:0];
    end
  end

  assign ctrl_word = {IMPL, VERS, sysctl_q, pso_q, 5'b0, nofault_q, en_q};
  assign ctp_word  = {ctp_q, 2'b00};
  assign ctx_word  = {{CTX_PAD{1'b0}}, ctx_q};

endmodule

// File: rtl/mmu_csr_sfault.sv
module mmu_csr_sfault
  import mmu_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  fault_rec_t        cap_rec,
  input  logic [7:0]        cap_space,
  input  logic [DATA_W-1:0] cap_vaddr,
  input  logic              nofault,
  input  logic              rd_status,
  output logic [DATA_W-1:0] status_word,
  output logic [DATA_W-1:0] addr_word,
  output logic              trap_q
);

  fault_rec_t        rec_q;
  logic              ow_q;
  logic              pend_q;
  logic [DATA_W-1:0] far_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q  <= '0;
      ow_q   <= 1'b0;
      pend_q <= 1'b0;
      far_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      // R6 R7: trap pulse one cycle after capture unless suppressed
      trap_q <= cap_valid && (!nofault || cap_space == TRAP_ALWAYS_SPACE);
      if (cap_valid) begin
        rec_q  <= cap_rec;
        // R8: a same-cycle read counts as the intervening read
        ow_q   <= pend_q && !rd_status;
        pend_q <= 1'b1;
        // R9: address register loads only for a valid address
        if (cap_rec.addr_ok) far_q <= cap_vaddr;
      end else if (rd_status) begin
        ow_q   <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  // R5: status layout, reserved upper bits zero
  assign status_word = {14'b0, rec_q.ebe, rec_q.level, rec_q.acc,
                        rec_q.ftype, rec_q.addr_ok, ow_q};
  assign addr_word   = far_q;

endmodule

// File: rtl/mmu_csr_afault.sv
module mmu_csr_afault
  import mmu_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic              cap_uce,
  input  logic              cap_bto,
  input  logic              cap_berr,
  input  logic [3:0]        cap_hi,
  input  logic [DATA_W-1:0] cap_addr,
  input  logic              rd_status,
  output logic [DATA_W-1:0] status_word,
  output logic [DATA_W-1:0] addr_word
);

  logic       uce_q, bto_q, berr_q, occ_q;
  logic [3:0] hi_q;
  logic [DATA_W-1:0] afar_q;

  // R10: capture all fields, read clears only the occurred flag
  always_ff @(posedge clk) begin
    if (rst) begin
      uce_q  <= 1'b0;
      bto_q  <= 1'b0;
      berr_q <= 1'b0;
      hi_q   <= '0;
      occ_q  <= 1'b0;
      afar_q <= '0;
    end else if (cap_valid) begin
      uce_q  <= cap_uce;
      bto_q  <= cap_bto;
      berr_q <= cap_berr;
      hi_q   <= cap_hi;
      occ_q  <= 1'b1;
      afar_q <= cap_addr;
    end else if (rd_status) begin
      occ_q  <= 1'b0;
    end
  end

  assign status_word = {19'b0, uce_q, bto_q, berr_q, 2'b00, hi_q, 3'b000, occ_q};
  assign addr_word   = afar_q;

endmodule

// File: rtl/mmu_csr.sv
module mmu_csr
  import mmu_csr_pkg::*;
#(
  parameter int         ADDR_W = 11,
  parameter int         CTX_W  = 8,
  parameter logic [3:0] IMPL   = 4'hA,
  parameter logic [3:0] VERS   = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              flt_valid,
  input  logic [7:0]        flt_ebe,
  input  logic [1:0]        flt_level,
  input  logic [2:0]        flt_acc,
  input  logic [2:0]        flt_type,
  input  logic              flt_addr_ok,
  input  logic [7:0]        flt_space,
  input  logic [31:0]       flt_vaddr,
  input  logic              afl_valid,
  input  logic              afl_uce,
  input  logic              afl_bto,
  input  logic              afl_berr,
  input  logic [3:0]        afl_hi,
  input  logic [31:0]       afl_addr,
  output logic              trap_req,
  output logic              xlat_en,
  output logic              pso_mode,
  output logic [31:0]       ctx_tbl_ptr,
  output logic [CTX_W-1:0]  ctx_id
);

  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  // R4: exact offset decode; wider buses also require upper bits zero
  logic     upper_zero;
  logic     hit;
  reg_sel_e sel;

  generate
    if (ADDR_W > IDX_MSB + 1) begin : g_upper
      assign upper_zero = (reg_addr[ADDR_W-1:IDX_MSB+1] == '0);
    end else begin : g_exact
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit = upper_zero && (reg_addr[IDX_LSB-1:0] == '0);
  assign sel = hit ? reg_sel_e'(reg_addr[IDX_MSB:IDX_LSB]) : SEL_NONE;

  logic wr_ctrl, wr_ctp, wr_ctx, rd_fsr, rd_afsr;
  assign wr_ctrl = reg_wr && sel == SEL_CTRL;
  assign wr_ctp  = reg_wr && sel == SEL_CTP;
  assign wr_ctx  = reg_wr && sel == SEL_CTX;
  assign rd_fsr  = reg_rd && sel == SEL_FSR;
  assign rd_afsr = reg_rd && sel == SEL_AFSR;

  logic [31:0] ctrl_w, ctp_w, ctx_w, fsr_w, far_w, afsr_w, afar_w;
  logic        nofault_w;

  mmu_csr_ctrl #(.IMPL(IMPL), .VERS(VERS), .CTX_W(CTX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr_ctrl), .wr_ctp(wr_ctp), .wr_ctx(wr_ctx), .wdata(reg_wdata),
    .ctrl_word(ctrl_w), .ctp_word(ctp_w), .ctx_word(ctx_w), .ctx_q(ctx_id),
    .en_q(xlat_en), .pso_q(pso_mode), .nofault_q(nofault_w)
  );

  fault_rec_t rec_in;
  assign rec_in = '{ebe: flt_ebe, level: flt_level, acc: flt_acc,
                    ftype: flt_type, addr_ok: flt_addr_ok};

  mmu_csr_sfault u_sfault (
    .clk(clk), .rst(rst),
    .cap_valid(flt_valid), .cap_rec(rec_in), .cap_space(flt_space),
    .cap_vaddr(flt_vaddr), .nofault(nofault_w), .rd_status(rd_fsr),
    .status_word(fsr_w), .addr_word(far_w), .trap_q(trap_req)
  );

  mmu_csr_afault u_afault (
    .clk(clk), .rst(rst),
    .cap_valid(afl_valid), .cap_uce(afl_uce), .cap_bto(afl_bto),
    .cap_berr(afl_berr), .cap_hi(afl_hi), .cap_addr(afl_addr),
    .rd_status(rd_afsr), .status_word(afsr_w), .addr_word(afar_w)
  );

  assign ctx_tbl_ptr = ctp_w;

  // R4: registered read mux, sampled before any read-clear takes effect
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (sel)
        SEL_CTRL: reg_rdata <= ctrl_w;
        SEL_CTP:  reg_rdata <= ctp_w;
        SEL_CTX:  reg_rdata <= ctx_w;
        SEL_FSR:  reg_rdata <= fsr_w;
        SEL_FAR:  reg_rdata <= far_w;
        SEL_AFSR: reg_rdata <= afsr_w;
        SEL_AFAR: reg_rdata <= afar_w;
        default:  reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mmu_csr_chk.sv
module mmu_csr_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              flt_valid,
  input logic              flt_addr_ok,
  input logic [7:0]        flt_space,
  input logic              trap_req,
  input logic              xlat_en,
  input logic              nofault,
  input logic [31:0]       fsr_word,
  input logic [31:0]       far_word
);

  logic rd_fsr_hit;
  assign rd_fsr_hit = reg_rd && reg_addr == ADDR_W'(12'h300);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!xlat_en && !trap_req));

  a_r6_trap_needs_capture: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(flt_valid));

  a_r7_suppressed_no_trap: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && nofault && flt_space != 8'd9) |=> !trap_req);

  a_r8_read_clears_ow: assert property (@(posedge clk) disable iff (rst)
    (rd_fsr_hit && !flt_valid) |=> (fsr_word[0] == 1'b0));

  a_r9_far_held: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !flt_addr_ok) |=> $stable(far_word));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_fsr_hit |=> (reg_rdata[31:18] == 14'h0));

endmodule

bind mmu_csr mmu_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .flt_valid(flt_valid), .flt_addr_ok(flt_addr_ok),
  .flt_space(flt_space), .trap_req(trap_req), .xlat_en(xlat_en),
  .nofault(nofault_w), .fsr_word(fsr_w), .far_word(far_w)
);

// File: tb/tb_mmu_csr.sv
module tb_mmu_csr;

  localparam int         AW  = 11;
  localparam int         CW  = 8;
  localparam logic [3:0] IMP = 4'hA;
  localparam logic [3:0] VER = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic flt_valid = 0, flt_addr_ok = 0;
  logic [7:0] flt_ebe = 0, flt_space = 0;
  logic [1:0] flt_level = 0;
  logic [2:0] flt_acc = 0, flt_type = 0;
  logic [31:0] flt_vaddr = 0;
  logic afl_valid = 0, afl_uce = 0, afl_bto = 0, afl_berr = 0;
  logic [3:0] afl_hi = 0;
  logic [31:0] afl_addr = 0;
  logic trap_req, xlat_en, pso_mode;
  logic [31:0] ctx_tbl_ptr;
  logic [CW-1:0] ctx_id;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mmu_csr #(.ADDR_W(AW), .CTX_W(CW), .IMPL(IMP), .VERS(VER)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    @(posedge clk); #1;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic set_fault(input logic [7:0] ebe, input logic [1:0] lv,
                           input logic [2:0] at, input logic [2:0] ft,
                           input logic ok, input logic [7:0] sp, input logic [31:0] va);
    flt_ebe = ebe; flt_level = lv; flt_acc = at; flt_type = ft;
    flt_addr_ok = ok; flt_space = sp; flt_vaddr = va; flt_valid = 1;
  endtask

  // one capture; check trap one cycle later and gone the cycle after
  task automatic fault(input logic [7:0] ebe, input logic [1:0] lv,
                       input logic [2:0] at, input logic [2:0] ft,
                       input logic ok, input logic [7:0] sp, input logic [31:0] va,
                       input logic exp_trap, input string tag);
    @(negedge clk);
    set_fault(ebe, lv, at, ft, ok, sp, va);
    @(posedge clk); #1;
    chk({tag, " trap pulse"}, {31'b0, trap_req}, {31'b0, exp_trap});
    @(negedge clk);
    flt_valid = 0;
    @(posedge clk); #1;
    chk({tag, " trap ends"}, {31'b0, trap_req}, 32'b0);
  endtask

  function automatic logic [31:0] fsr_exp(input logic [7:0] ebe, input logic [1:0] lv,
                                          input logic [2:0] at, input logic [2:0] ft,
                                          input logic ok, input logic ow);
    return (32'(ebe) << 10) | (32'(lv) << 8) | (32'(at) << 5) | (32'(ft) << 2)
           | (32'(ok) << 1) | 32'(ow);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(posedge clk); #1;
    // R1
    chk("R1 xlat_en", {31'b0, xlat_en}, 0);
    chk("R1 pso_mode", {31'b0, pso_mode}, 0);
    chk("R1 trap_req", {31'b0, trap_req}, 0);
    rd(11'h000, d); chk("R1 ctrl reset", d, {IMP, VER, 24'h0});
    rd(11'h300, d); chk("R1 fsr reset", d, 0);

    // R2
    wr(11'h000, 32'hFFFF_FFFF);
    rd(11'h000, d); chk("R2 ctrl all ones", d, {IMP, VER, 16'hFFFF, 8'h83});
    chk("R2 xlat_en", {31'b0, xlat_en}, 1);
    chk("R2 pso_mode", {31'b0, pso_mode}, 1);
    wr(11'h000, 32'h0000_1201);
    rd(11'h000, d); chk("R2 ctrl pattern", d, {IMP, VER, 24'h001201});
    chk("R2 pso cleared", {31'b0, pso_mode}, 0);

    // R3
    wr(11'h100, 32'hDEAD_BEEF);
    rd(11'h100, d); chk("R3 ctp read", d, 32'hDEAD_BEEC);
    chk("R3 ctp port", ctx_tbl_ptr, 32'hDEAD_BEEC);
    wr(11'h200, 32'h1234_56AB);
    rd(11'h200, d); chk("R3 ctx read", d, 32'h0000_00AB);
    chk("R3 ctx port", {24'b0, ctx_id}, 32'hAB);

    // R4: read-only writes ignored, unmapped and misaligned offsets
    wr(11'h300, 32'hFFFF_FFFF);
    rd(11'h300, d); chk("R4 fsr write ignored", d, 0);
    wr(11'h400, 32'h1111_1111);
    rd(11'h400, d); chk("R4 far write ignored", d, 0);
    wr(11'h700, 32'hFFFF_FFFF);
    rd(11'h700, d); chk("R4 unmapped reads zero", d, 0);
    wr(11'h004, 32'h0000_0000);
    rd(11'h004, d); chk("R4 misaligned reads zero", d, 0);
    rd(11'h000, d); chk("R4 ctrl untouched", d, {IMP, VER, 24'h001201});

    // R5 R6: sweep all access and fault type codes, trap enabled
    for (int at = 0; at < 8; at++) begin
      for (int ft = 0; ft < 8; ft++) begin
        logic [7:0] ebe;
        ebe = 8'((at * 37 + ft * 11) ^ 8'h5A);
        fault(ebe, 2'(at + ft), 3'(at), 3'(ft), 1'b1, 8'h0B, 32'h8000_0000 | 32'(at * 8 + ft),
              1'b1, "R6 sweep");
        rd(11'h300, d);
        chk("R5 fsr fields", d, fsr_exp(ebe, 2'(at + ft), 3'(at), 3'(ft), 1'b1, 1'b0));
        rd(11'h400, d);
        chk("R9 far load", d, 32'h8000_0000 | 32'(at * 8 + ft));
      end
    end

    // R7: suppress-trap mode
    wr(11'h000, 32'h0000_0003);
    fault(8'h01, 2'd1, 3'd4, 3'd2, 1'b1, 8'h0B, 32'h0000_1000, 1'b0, "R7 suppressed");
    rd(11'h300, d); chk("R7 still recorded", d, fsr_exp(8'h01, 2'd1, 3'd4, 3'd2, 1'b1, 1'b0));
    fault(8'h02, 2'd2, 3'd5, 3'd3, 1'b1, 8'd9, 32'h0000_2000, 1'b1, "R7 space 9 traps");
    rd(11'h300, d); chk("R7 space 9 record", d, fsr_exp(8'h02, 2'd2, 3'd5, 3'd3, 1'b1, 1'b0));
    wr(11'h000, 32'h0000_0001);

    // R8: back-to-back captures set overwrite; read returns then clears it
    fault(8'h10, 2'd0, 3'd0, 3'd1, 1'b1, 8'h0B, 32'hA000_0000, 1'b1, "R8 first");
    fault(8'h20, 2'd3, 3'd7, 3'd4, 1'b1, 8'h0B, 32'hB000_0000, 1'b1, "R8 second");
    rd(11'h300, d); chk("R8 overwrite set", d, fsr_exp(8'h20, 2'd3, 3'd7, 3'd4, 1'b1, 1'b1));
    rd(11'h300, d); chk("R8 overwrite cleared", d, fsr_exp(8'h20, 2'd3, 3'd7, 3'd4, 1'b1, 1'b0));
    // R8: capture coinciding with a status read
    fault(8'h33, 2'd1, 3'd2, 3'd5, 1'b1, 8'h0B, 32'hC000_0000, 1'b1, "R8 pre");
    @(negedge clk);
    set_fault(8'h44, 2'd2, 3'd3, 3'd6, 1'b1, 8'h0B, 32'hD000_0000);
    reg_addr = 11'h300; reg_rd = 1;
    @(posedge clk); #1;
    chk("R8 same-cycle read old value", reg_rdata, fsr_exp(8'h33, 2'd1, 3'd2, 3'd5, 1'b1, 1'b0));
    @(negedge clk);
    flt_valid = 0; reg_rd = 0;
    rd(11'h300, d); chk("R8 same-cycle new record no ow", d, fsr_exp(8'h44, 2'd2, 3'd3, 3'd6, 1'b1, 1'b0));

    // R9: invalid address keeps the old fault address
    fault(8'h00, 2'd1, 3'd1, 3'd1, 1'b1, 8'h0B, 32'h1234_5678, 1'b1, "R9 valid");
    fault(8'h00, 2'd1, 3'd1, 3'd1, 1'b0, 8'h0B, 32'h8765_4321, 1'b1, "R9 invalid");
    rd(11'h400, d); chk("R9 far kept", d, 32'h1234_5678);
    rd(11'h300, d); chk("R9 fav clear", d & 32'h2, 0);

    // R10: async sweep over the high nibble and flag combinations
    for (int h = 0; h < 16; h++) begin
      logic [31:0] e;
      @(negedge clk);
      afl_valid = 1; afl_hi = 4'(h);
      afl_uce = h[0]; afl_bto = h[1]; afl_berr = h[2];
      afl_addr = 32'hF000_0000 + 32'(h * 4);
      @(negedge clk);
      afl_valid = 0;
      e = (32'(h[0]) << 12) | (32'(h[1]) << 11) | (32'(h[2]) << 10) | (32'(h) << 4) | 32'h1;
      rd(11'h500, d); chk("R10 afsr capture", d, e);
      rd(11'h600, d); chk("R10 afar capture", d, 32'hF000_0000 + 32'(h * 4));
      rd(11'h500, d); chk("R10 afsr read clears occurred", d, e & ~32'h1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule